// File: doc/BRIEF.md
# SPI Register-Read Command Sequencer

This block is an SPI master that fetches a run of consecutive registers from an external converter. A single start pulse launches the whole transaction. The block sends a command that stops continuous conversion output, then a two-byte read command built from the starting address and the register count. It then clocks the requested register bytes back from the device.

The device needs time to decode each command byte. After every command byte the sequencer therefore holds the bus idle for a programmable number of system clocks. The gap is measured from the last SCLK edge of one byte to the first SCLK edge of the next. Readback bytes need no decoding, so they run back to back with no gap.

Each received byte appears on a parallel output together with a one-cycle valid strobe. When a read starts at register 0, the first returned byte is compared against the expected identity value and the result is shown on a flag. A one-cycle done pulse closes every transaction.

Top module: `regread_seq`

## Requirements
- R1: On an accepted start, cs_n falls and three command bytes go out in this order: STOP_CMD (default 0x11), then 0x20 OR'd with the 5-bit start address, then the register count minus one (`nregs_m1`, upper three bits zero).
- R2: SPI mode: SCLK idles low, MOSI changes only on a rising SCLK edge, MISO is sampled on the falling edge, and bytes travel MSB first.
- R3: After each command byte, at least GAP_CYC system clocks pass from that byte's last falling SCLK edge to the next byte's first rising edge, and SCLK stays low throughout.
- R4: cs_n stays low from the first command byte until the last readback byte completes, with no high pulse in between. SCLK is low whenever cs_n is high.
- R5: Readback bytes are clocked back to back: the time from the last fall of one data byte to the first rise of the next equals exactly CLK_HALF system clocks. MOSI carries 0x00 during readback.
- R6: Every SCLK high phase and low phase within a byte lasts CLK_HALF system clocks. The defaults (32 clocks at 250 MHz) give an SCLK frequency below 4 MHz.
- R7: Exactly `nregs_m1`+1 bytes are delivered on rd_data, in register order, each with a one-cycle rd_valid pulse.
- R8: id_ok clears on an accepted start. It is set only when the transaction starts at address 0 and the first returned byte equals ID_VALUE (default 0xB4). It then holds until the next start.
- R9: done is a single-cycle pulse issued after cs_n has returned high. busy is low again from that point on.
- R10: A start pulse while busy is ignored: the running transaction and the bytes it sends are unchanged, and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, one cycle |
| start_addr | input | 5 | First register to read |
| nregs_m1 | input | 5 | Number of registers minus one |
| miso | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the device |
| busy | output | 1 | A transaction is in progress |
| rd_data | output | 8 | Last received register byte |
| rd_valid | output | 1 | rd_data is new this cycle |
| id_ok | output | 1 | Identity byte matched |
| done | output | 1 | Transaction-complete pulse |

## Verification
The assertions assume that reset is released synchronously. They also assume that the device changes MISO only while SCLK is high or cs_n is high, so the sample taken on the falling edge is stable. The bench's device model drives MISO from the rising SCLK edge and otherwise leaves it untouched. The bench asserts start for a single clock, and it changes start_addr and nregs_m1 only in the cycle it asserts start, including when it deliberately pokes start during a busy transaction.

// File: rtl/regread_pkg.sv
package regread_pkg;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SH_CMD,
    ST_GAP,
    ST_SH_DATA,
    ST_FIN
  } seq_state_t;

  // first byte of the register-read command
  function automatic logic [7:0] rreg_opcode(input logic [ADDR_W-1:0] addr);
    return 8'h20 | {3'b000, addr};
  endfunction

  // second byte of the register-read command: count minus one
  function automatic logic [7:0] rreg_count(input logic [ADDR_W-1:0] m1);
    return {3'b000, m1};
  endfunction
endpackage

// File: rtl/rrs_byte_shifter.sv
module rrs_byte_shifter #(
  parameter int HALF = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active;
  logic [CW-1:0] cnt;
  logic [2:0]    bits;
  logic [7:0]    tx_sr;
  logic [6:0]    rx_sr;
  logic          tick;

  assign tick      = active && (cnt == CW'(HALF - 1));
  // event wire: the eighth falling edge of the byte
  assign byte_done = tick && sclk && (bits == 3'd7);
  assign rx_byte   = {rx_sr, miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bits   <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
    end else begin
      if (active) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) begin
        sclk <= ~sclk;
        if (!sclk) begin
          mosi  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end else begin
          rx_sr <= {rx_sr[5:0], miso};
          bits  <= bits + 3'd1;
          if (bits == 3'd7) active <= 1'b0;
        end
      end
      if (load) begin
        active <= 1'b1;
        cnt    <= '0;
        bits   <= '0;
        tx_sr  <= load_byte;
      end
    end
  end
endmodule

// File: rtl/rrs_gap_timer.sv
module rrs_gap_timer #(
  parameter int GAP = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic running,
  output logic expire
);
  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

  logic [CW-1:0] cnt;

  assign expire = running && (cnt == CW'(GAP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (arm) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/regread_seq.sv
module regread_seq
  import regread_pkg::*;
#(
  parameter int         CLK_HALF = 32,
  parameter int         GAP_CYC  = 512,
  parameter logic [7:0] STOP_CMD = 8'h11,
  parameter logic [7:0] ID_VALUE = 8'hB4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] nregs_m1,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic              busy,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              id_ok,
  output logic              done
);
  seq_state_t        state;
  logic [1:0]        cmd_idx;
  logic [ADDR_W-1:0] addr_q, m1_q, left;
  logic              first_q;

  // named event wires between the sequencer and its helpers
  logic       load;
  logic [7:0] load_byte;
  logic       byte_done;
  logic [7:0] rx_byte;
  logic       gap_arm;
  logic       gap_done;
  logic       gap_running;

  rrs_byte_shifter #(.HALF(CLK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte),
    .miso(miso), .sclk(sclk), .mosi(mosi),
    .byte_done(byte_done), .rx_byte(rx_byte)
  );

  rrs_gap_timer #(.GAP(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .arm(gap_arm),
    .running(gap_running), .expire(gap_done)
  );

  assign busy = (state != ST_IDLE);

  always_comb begin
    load      = 1'b0;
    load_byte = 8'h00;
    gap_arm   = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        load      = 1'b1;
        load_byte = STOP_CMD;
      end
      ST_SH_CMD: gap_arm = byte_done;
      ST_GAP: if (gap_done) begin
        load = 1'b1;
        if (cmd_idx == 2'd1)      load_byte = rreg_opcode(addr_q);
        else if (cmd_idx == 2'd2) load_byte = rreg_count(m1_q);
        else                      load_byte = 8'h00;
      end
      ST_SH_DATA: load = byte_done && (left != '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_idx  <= '0;
      addr_q   <= '0;
      m1_q     <= '0;
      left     <= '0;
      first_q  <= 1'b0;
      cs_n     <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      id_ok    <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cs_n    <= 1'b0;
          addr_q  <= start_addr;
          m1_q    <= nregs_m1;
          cmd_idx <= '0;
          id_ok   <= 1'b0;
          state   <= ST_SH_CMD;
        end
        ST_SH_CMD: if (byte_done) begin
          cmd_idx <= cmd_idx + 2'd1;
          state   <= ST_GAP;
        end
        ST_GAP: if (gap_done) begin
          if (cmd_idx == 2'd3) begin
            state   <= ST_SH_DATA;
            left    <= m1_q;
            first_q <= 1'b1;
          end else begin
            state <= ST_SH_CMD;
          end
        end
        ST_SH_DATA: if (byte_done) begin
          rd_valid <= 1'b1;
          rd_data  <= rx_byte;
          first_q  <= 1'b0;
          if (first_q && addr_q == '0) id_ok <= (rx_byte == ID_VALUE);
          if (left == '0) begin
            cs_n  <= 1'b1;
            state <= ST_FIN;
          end else begin
            left <= left - 1'b1;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regread_seq_chk.sv
module regread_seq_chk #(
  parameter logic [7:0] ID_VALUE = 8'hB4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       done,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       id_ok,
  input logic       gap_running
);
  assert_mosi_moves_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $rose(sclk));

  assert_no_clock_in_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_running |-> !sclk);

  assert_sclk_low_outside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_id_from_matching_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_ok) |-> (rd_valid && rd_data == ID_VALUE));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
endmodule

bind regread_seq regread_seq_chk #(.ID_VALUE(ID_VALUE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .done(done), .rd_valid(rd_valid), .rd_data(rd_data), .id_ok(id_ok),
  .gap_running(gap_running)
);

// File: tb/test_regread_seq.sv
`timescale 1ns/1ps
module test_regread_seq;
  localparam int         HALF = 32;
  localparam int         GAP  = 512;
  localparam int         TCK  = 4;
  localparam logic [7:0] STOP = 8'h11;
  localparam logic [7:0] IDV  = 8'hB4;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [4:0] addr_in = '0, m1_in = '0;
  logic       sclk, cs_n, mosi, busy, rd_valid, id_ok, done;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  regread_seq i_regread_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(addr_in),
    .nregs_m1(m1_in), .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid), .id_ok(id_ok),
    .done(done)
  );

  int  total = 0, bad = 0;
  bit  finished = 0;
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_data[$];
  logic [7:0] dev_id = 8'hB4;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_reg(input logic [4:0] a);
    if (a == 5'd0) return dev_id;
    return 8'({3'b000, a} * 8'h1D + 8'h03);
  endfunction

  // device model: shifts out on rising SCLK, captures MOSI on falling
  int         bitn = 0;
  logic [7:0] sh_in = '0;
  logic [4:0] dev_addr = '0;
  longint     t_fall = 0, t_rise = 0;
  bit         last_cmd = 1'b0;

  always @(negedge cs_n) bitn = 0;

  always @(posedge sclk) begin
    int bi;
    logic [7:0] v;
    bi = bitn / 8;
    if (bitn % 8 == 0 && bitn > 0) begin
      if (last_cmd) check(($time - t_fall) >= GAP * TCK, "R3 gap", int'($time - t_fall), GAP * TCK);
      else check(($time - t_fall) == HALF * TCK, "R5 spacing", int'($time - t_fall), HALF * TCK);
    end else if (bitn > 0) begin
      check(($time - t_fall) == HALF * TCK, "R6 low phase", int'($time - t_fall), HALF * TCK);
    end
    t_rise = $time;
    if (bi >= 3) begin
      v = dev_reg(dev_addr + 5'(bi - 3));
      miso <= v[7 - (bitn % 8)];
    end else begin
      miso <= 1'b0;
    end
  end

  always @(negedge sclk) begin
    check(($time - t_rise) == HALF * TCK, "R6 high phase", int'($time - t_rise), HALF * TCK);
    sh_in = {sh_in[6:0], mosi};
    bitn++;
    t_fall = $time;
    if (bitn % 8 == 0) begin
      last_cmd = (bitn / 8 <= 3);
      if (bitn / 8 == 2) dev_addr = sh_in[4:0];
      if (exp_mosi.size() == 0) check(0, "R1 extra byte", sh_in, 0);
      else begin
        logic [7:0] e;
        e = exp_mosi.pop_front();
        check(sh_in == e, (bitn / 8 <= 3) ? "R1 R2 command byte" : "R5 dummy byte", sh_in, e);
      end
    end
  end

  always @(posedge cs_n) if (rst_n)
    check(exp_mosi.size() == 0, "R4 cs_n high early", exp_mosi.size(), 0);

  // scoreboard monitor for readback bytes
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_data.size() == 0) check(0, "R7 extra byte", rd_data, 0);
    else begin
      logic [7:0] e;
      e = exp_data.pop_front();
      check(rd_data == e, "R2 R7 readback", rd_data, e);
    end
  end

  task automatic run_txn(input logic [4:0] a, input logic [4:0] m1, input bit poke);
    int n;
    bit want_id;
    want_id = (a == 5'd0) && (dev_id == IDV);
    exp_mosi.push_back(STOP);
    exp_mosi.push_back(8'h20 | {3'b000, a});
    exp_mosi.push_back({3'b000, m1});
    for (int k = 0; k <= int'(m1); k++) begin
      exp_mosi.push_back(8'h00);
      exp_data.push_back(dev_reg(a + 5'(k)));
    end
    @(negedge clk);
    addr_in = a; m1_in = m1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !cs_n, "R1 start accepted", {busy, cs_n}, 2'b10);
    check(!id_ok, "R8 id_ok cleared on start", id_ok, 0);
    if (poke) begin
      repeat (700) @(negedge clk);
      addr_in = a + 5'd1; m1_in = m1 + 5'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check(done, "R9 done seen", done, 1);
    check(cs_n, "R9 cs_n high at done", cs_n, 1);
    check(exp_data.size() == 0, "R7 all bytes delivered", exp_data.size(), 0);
    @(negedge clk);
    check(!done && !busy, "R9 done single cycle", {done, busy}, 0);
    check(id_ok == want_id, "R8 id_ok", id_ok, want_id);
    if (poke) begin
      repeat (200) @(negedge clk);
      check(cs_n && !busy, "R10 no second transaction", {cs_n, busy}, 2'b10);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cs_n && !sclk && !busy && !done && !id_ok && !rd_valid,
          "R4 R9 reset state", {cs_n, sclk, busy, done, id_ok, rd_valid}, 6'b100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_txn(5'd0, 5'd0, 1'b0);
    run_txn(5'd0, 5'd3, 1'b0);
    run_txn(5'd5, 5'd2, 1'b1);
    run_txn(5'd31, 5'd1, 1'b0);
    dev_id = 8'hB5;
    run_txn(5'd0, 5'd0, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule